// File: doc/BRIEF.md
# Device-Side ATA Task-File Register Block

This block is the register file a storage device exposes to its host over a small read/write bus. The host picks a register with a 4-bit offset and two byte-lane selects, then pulses a read or write strobe. Behind the bus sit the byte-wide task registers: feature, sector count, sector number, cylinder low, cylinder high and drive/head. Beside them are a command register, which issues a one-cycle strobe to the internal controller, and a device-control register. The status byte is built from the block's own busy flag and from status lines driven by the controller.

The task registers also drive a 28-bit logical block address for the controller. The busy flag and the pending-interrupt flag are kept here. An interrupt output is masked by a device-control bit. Status can be read through two offsets. Only one of them acknowledges a pending interrupt. While a command is in progress, the host may still write device control, but every other task register and the command register are frozen.

Top module: `tf_regfile`

## Requirements
- R1: After reset, the task registers read as 0x00, the feature output is 0x00, busy is clear, no interrupt is pending, the interrupt mask bit is clear, and the command strobe is low.
- R2: A low-lane byte write (host_sel = 01) to offsets 2 to 6 stores the byte, and a low-lane read of the same offset returns it on host_rdata[7:0] with the upper byte zero. Offset 2 is the sector count, which also drives count_o.
- R3: lba_o is {drive/head[3:0], cylinder high, cylinder low, sector number}, taken from offsets 6, 5, 4 and 3. lba_mode_o is drive/head bit 6.
- R4: A low-lane read of offset 7 or offset 14 returns this status byte: bit 7 busy, bit 6 ctl_ready, bit 5 ctl_fault, bit 4 ctl_seek, bit 3 ctl_drq, bits 2 and 1 zero, bit 0 ctl_err.
- R5: A low-lane write to offset 7 while not busy raises cmd_stb for exactly the next cycle, with cmd_code equal to the written byte. Busy reads as set from that same cycle on, and any pending interrupt is cleared.
- R6: While busy is set, writes to offset 7 are ignored (no strobe, cmd_code unchanged). Writes to offsets 1 to 6 and odd-lane feature writes are also ignored.
- R7: A low-lane write to offset 14 stores bit 1 as the interrupt mask, even while busy. irq_o is high only when an interrupt is pending and the mask bit is 0.
- R8: A low-lane read of offset 7 clears the pending interrupt. A read of offset 14 leaves it pending.
- R9: An odd-lane-only access (host_sel = 10) at offset 0 reads the controller error code on host_rdata[7:0] and writes the feature register from host_wdata[7:0]. A low-lane access at offset 1 does the same.
- R10: An access at offset 0 with host_sel[0] set is a data-port access. During the access cycle, dp_wr_stb or dp_rd_stb is high, dp_wdata carries host_wdata, and host_rdata carries dp_rdata.
- R11: A ctl_done pulse while busy clears busy and sets the pending interrupt from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 4 | Register offset |
| host_sel | input | 2 | Byte-lane selects (bit 0 low lane, bit 1 high/odd lane) |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational |
| dp_rd_stb | output | 1 | Data-port read strobe to controller |
| dp_wr_stb | output | 1 | Data-port write strobe to controller |
| dp_wdata | output | 16 | Data-port write word |
| dp_rdata | input | 16 | Data-port read word from controller |
| ctl_ready | input | 1 | Controller ready |
| ctl_fault | input | 1 | Controller write fault |
| ctl_seek | input | 1 | Controller seek complete |
| ctl_drq | input | 1 | Controller data request |
| ctl_err | input | 1 | Controller error flag |
| ctl_err_code | input | 8 | Controller error register value |
| ctl_done | input | 1 | Command completion pulse |
| cmd_stb | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 8 | Last accepted command byte |
| feat_o | output | 8 | Feature register |
| count_o | output | 8 | Sector count register |
| lba_o | output | 28 | Assembled block address |
| lba_mode_o | output | 1 | Address-mode bit from drive/head |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and the data-port strobes are combinational. The bench therefore samples them 1 ns after it drives the access, before the capturing edge. Register contents, cmd_stb, busy and the interrupt flag change at the edge that ends the access. They are checked at the falling edge that follows it. cmd_stb is checked again one cycle later, when it must be low. After a ctl_done pulse, irq_o is sampled at the very next falling edge. Random register values and random controller status bits are checked against values computed by bench functions.

// File: rtl/tf_pkg.sv
package tf_pkg;
   localparam int TF_OFF_FEAT  = 1;
   localparam int TF_OFF_COUNT = 2;
   localparam int TF_OFF_HEAD  = 6;
   localparam int TF_OFF_CMD   = 7;
   localparam int TF_OFF_CTRL  = 14;
   localparam int TF_NIEN_BIT  = 1;
   localparam int TF_LBAM_BIT  = 6;
   localparam int TF_NTASK     = 8;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_ODD  = 2'd2,
      ACC_LOW  = 2'd3
   } acc_e;
endpackage

// File: rtl/tf_decode.sv
module tf_decode
   import tf_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           sel,
   output acc_e                 kind,
   output logic [TF_NTASK-1:1]  hit,
   output logic                 hit_ctrl
);
   localparam logic [ADDR_W-1:0] A_ZERO = '0;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(TF_OFF_CTRL);

   for (genvar gi = 1; gi < TF_NTASK; gi++) begin : g_hit
      localparam logic [ADDR_W-1:0] A_I = ADDR_W'(gi);
      assign hit[gi] = (addr == A_I);
   end

   assign hit_ctrl = (addr == A_CTRL);

   always_comb begin
      if (addr == A_ZERO) begin
         if (sel[0])      kind = ACC_DATA;
         else if (sel[1]) kind = ACC_ODD;
         else             kind = ACC_NONE;
      end else begin
         kind = sel[0] ? ACC_LOW : ACC_NONE;
      end
   end
endmodule

// File: rtl/tf_taskregs.sv
module tf_taskregs #(
   parameter int NREG = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  busy,
   input  logic [NREG-1:0]       we,
   input  logic [7:0]            wbyte,
   output logic [NREG-1:0][7:0]  regs
);
   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                regs[gi] <= 8'h00;
         else if (we[gi] && !busy)  regs[gi] <= wbyte;
      end
   end
endmodule

// File: rtl/tf_stat_irq.sv
module tf_stat_irq
   import tf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic       ctrl_we,
   input  logic       stat_rd,
   input  logic       ctl_done,
   input  logic [7:0] wbyte,
   output logic       busy_q,
   output logic       pend_q,
   output logic       cmd_stb,
   output logic [7:0] cmd_code,
   output logic       irq
);
   logic nien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pend_q   <= 1'b0;
         cmd_stb  <= 1'b0;
         cmd_code <= 8'h00;
         nien_q   <= 1'b0;
      end else begin
         cmd_stb <= 1'b0;
         if (ctl_done && busy_q) begin
            busy_q <= 1'b0;
            pend_q <= 1'b1;
         end else if (cmd_we && !busy_q) begin
            busy_q   <= 1'b1;
            cmd_stb  <= 1'b1;
            cmd_code <= wbyte;
            pend_q   <= 1'b0;
         end else if (stat_rd) begin
            pend_q <= 1'b0;
         end
         if (ctrl_we) nien_q <= wbyte[TF_NIEN_BIT];
      end
   end

   assign irq = pend_q & ~nien_q;
endmodule

// File: rtl/tf_regfile.sv
module tf_regfile
   import tf_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [1:0]        host_sel,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              dp_rd_stb,
   output logic              dp_wr_stb,
   output logic [DATA_W-1:0] dp_wdata,
   input  logic [DATA_W-1:0] dp_rdata,
   input  logic              ctl_ready,
   input  logic              ctl_fault,
   input  logic              ctl_seek,
   input  logic              ctl_drq,
   input  logic              ctl_err,
   input  logic [7:0]        ctl_err_code,
   input  logic              ctl_done,
   output logic              cmd_stb,
   output logic [7:0]        cmd_code,
   output logic [7:0]        feat_o,
   output logic [7:0]        count_o,
   output logic [27:0]       lba_o,
   output logic              lba_mode_o,
   output logic              irq_o
);
   localparam int NREG  = TF_OFF_HEAD - TF_OFF_FEAT + 1;
   localparam int PAD_W = DATA_W - 8;

   if (DATA_W != 16) begin : g_bad_data
      $error("tf_regfile: DATA_W must be 16");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("tf_regfile: ADDR_W must be at least 4");
   end

   acc_e                kind;
   logic [TF_NTASK-1:1] hit;
   logic                hit_ctrl;
   logic [NREG-1:0]     tr_we;
   logic [NREG-1:0][7:0] regs;
   logic                busy_q;
   logic                pend_q;
   logic [7:0]          status;
   logic [7:0]          rd_byte;
   logic                low_wr;

   tf_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(host_addr), .sel(host_sel), .kind(kind), .hit(hit), .hit_ctrl(hit_ctrl)
   );

   assign low_wr = host_wr && (kind == ACC_LOW);

   for (genvar gi = 0; gi < NREG; gi++) begin : g_we
      if (gi == 0) begin : g_feat
         assign tr_we[gi] = (low_wr && hit[TF_OFF_FEAT]) || (host_wr && kind == ACC_ODD);
      end else begin : g_task
         assign tr_we[gi] = low_wr && hit[gi + TF_OFF_FEAT];
      end
   end

   tf_taskregs #(.NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .busy(busy_q), .we(tr_we),
      .wbyte(host_wdata[7:0]), .regs(regs)
   );

   tf_stat_irq u_stat (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(low_wr && hit[TF_OFF_CMD]),
      .ctrl_we(low_wr && hit_ctrl),
      .stat_rd(host_rd && kind == ACC_LOW && hit[TF_OFF_CMD]),
      .ctl_done(ctl_done), .wbyte(host_wdata[7:0]),
      .busy_q(busy_q), .pend_q(pend_q),
      .cmd_stb(cmd_stb), .cmd_code(cmd_code), .irq(irq_o)
   );

   assign status = {busy_q, ctl_ready, ctl_fault, ctl_seek, ctl_drq, 2'b00, ctl_err};

   always_comb begin
      rd_byte = 8'h00;
      if (hit[TF_OFF_FEAT]) rd_byte = ctl_err_code;
      for (int i = 1; i < NREG; i++) begin
         if (hit[i + TF_OFF_FEAT]) rd_byte = regs[i];
      end
      if (hit[TF_OFF_CMD] || hit_ctrl) rd_byte = status;
      case (kind)
         ACC_DATA: host_rdata = dp_rdata;
         ACC_ODD:  host_rdata = {{PAD_W{1'b0}}, ctl_err_code};
         ACC_LOW:  host_rdata = {{PAD_W{1'b0}}, rd_byte};
         default:  host_rdata = '0;
      endcase
   end

   assign dp_rd_stb  = host_rd && (kind == ACC_DATA);
   assign dp_wr_stb  = host_wr && (kind == ACC_DATA);
   assign dp_wdata   = host_wdata;
   assign feat_o     = regs[0];
   assign count_o    = regs[TF_OFF_COUNT - TF_OFF_FEAT];
   assign lba_o      = {regs[5][3:0], regs[4], regs[3], regs[2]};
   assign lba_mode_o = regs[5][TF_LBAM_BIT];
endmodule

// File: rtl/tf_regfile_chk.sv
module tf_regfile_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic              sel_low,
   input logic [7:0]        wbyte,
   input logic              ctl_done,
   input logic              cmd_stb,
   input logic [7:0]        cmd_code,
   input logic              busy_q,
   input logic              pend_q,
   input logic [27:0]       lba_o
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(7);
   localparam logic [ADDR_W-1:0] A_ALT = ADDR_W'(14);

   a_r5_cmd_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && sel_low && host_addr == A_CMD && !busy_q)
      |=> (cmd_stb && busy_q && cmd_code == $past(wbyte)));

   a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);

   a_r6_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == A_CMD && busy_q) |=> !cmd_stb);

   a_r6_task_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(lba_o));

   a_r11_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_done && busy_q) |=> (!busy_q && pend_q));

   a_r8_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && sel_low && host_addr == A_ALT && pend_q) |=> pend_q);

   a_r8_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && sel_low && host_addr == A_CMD && !(ctl_done && busy_q))
      |=> !pend_q);
endmodule

bind tf_regfile tf_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_addr(host_addr), .sel_low(host_sel[0]), .wbyte(host_wdata[7:0]),
   .ctl_done(ctl_done), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
   .busy_q(busy_q), .pend_q(pend_q), .lba_o(lba_o)
);

// File: tb/tf_regfile_tb.sv
`timescale 1ns/1ps
module tf_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [1:0]  host_sel = '0;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_wdata = '0, host_rdata, dp_wdata, dp_rdata = '0;
   logic        dp_rd_stb, dp_wr_stb;
   logic        ctl_ready = 0, ctl_fault = 0, ctl_seek = 0, ctl_drq = 0, ctl_err = 0;
   logic [7:0]  ctl_err_code = '0;
   logic        ctl_done = 1'b0;
   logic        cmd_stb, lba_mode_o, irq_o;
   logic [7:0]  cmd_code, feat_o, count_o;
   logic [27:0] lba_o;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] m_reg [2:6];

   always #2 clk = ~clk;

   tf_regfile u_dut (.*);

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(logic busy);
      return {busy, ctl_ready, ctl_fault, ctl_seek, ctl_drq, 2'b00, ctl_err};
   endfunction

   function automatic logic [27:0] exp_lba();
      return {m_reg[6][3:0], m_reg[5], m_reg[4], m_reg[3]};
   endfunction

   task automatic bus_wr(logic [3:0] a, logic [1:0] s, logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_sel = s; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_sel = 2'b00;
   endtask

   task automatic bus_rd(logic [3:0] a, logic [1:0] s, output logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_sel = s; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0; host_sel = 2'b00;
   endtask

   task automatic done_pulse();
      @(negedge clk); ctl_done = 1'b1;
      @(negedge clk); ctl_done = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      logic [7:0]  v;
      logic [7:0]  code;
      void'($urandom(32'd4242));
      for (int i = 2; i <= 6; i++) m_reg[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 2; i <= 6; i++) begin
         bus_rd(4'(i), 2'b01, rd);
         chk("R1 task reg reset", 32'(rd), 32'h0);
      end
      bus_rd(4'd14, 2'b01, rd);
      chk("R1 status reset", 32'(rd), 32'h0);
      chk("R1 irq reset", 32'(irq_o), 32'h0);
      chk("R1 cmd_stb reset", 32'(cmd_stb), 32'h0);
      chk("R1 feature reset", 32'(feat_o), 32'h0);

      // R4: status layout
      ctl_ready = 1; ctl_seek = 1;
      bus_rd(4'd14, 2'b01, rd);
      chk("R4 status ready+seek", 32'(rd), 32'h50);
      for (int k = 0; k < 6; k++) begin
         {ctl_ready, ctl_fault, ctl_seek, ctl_drq, ctl_err} = 5'($urandom);
         bus_rd((k % 2) ? 4'd7 : 4'd14, 2'b01, rd);
         chk("R4 status random", 32'(rd), 32'(exp_status(1'b0)));
      end

      // R2 / R3: task registers and address assembly
      for (int k = 0; k < 8; k++) begin
         for (int i = 2; i <= 6; i++) begin
            v = 8'($urandom);
            if (k == 0) v = 8'hFF;
            m_reg[i] = v;
            bus_wr(4'(i), 2'b01, {8'($urandom), v});
         end
         for (int i = 2; i <= 6; i++) begin
            bus_rd(4'(i), 2'b01, rd);
            chk("R2 readback", 32'(rd), 32'(m_reg[i]));
         end
         chk("R2 count_o", 32'(count_o), 32'(m_reg[2]));
         chk("R3 lba", 32'(lba_o), 32'(exp_lba()));
         chk("R3 lba mode", 32'(lba_mode_o), 32'(m_reg[6][6]));
      end

      // R9: odd-lane access at offset 0
      ctl_err_code = 8'hA5;
      bus_wr(4'd0, 2'b10, 16'h003C);
      chk("R9 odd write feature", 32'(feat_o), 32'h3C);
      bus_wr(4'd1, 2'b01, 16'h0071);
      chk("R9 offset1 write feature", 32'(feat_o), 32'h71);
      bus_rd(4'd0, 2'b10, rd);
      chk("R9 odd read error", 32'(rd), 32'hA5);
      bus_rd(4'd1, 2'b01, rd);
      chk("R9 offset1 read error", 32'(rd), 32'hA5);

      // R10: data port
      @(negedge clk);
      host_addr = 4'd0; host_sel = 2'b11; host_wdata = 16'h1234; host_wr = 1'b1;
      #1;
      chk("R10 dp_wr_stb", 32'(dp_wr_stb), 32'h1);
      chk("R10 dp_wdata", 32'(dp_wdata), 32'h1234);
      chk("R10 dp_rd_stb idle", 32'(dp_rd_stb), 32'h0);
      @(negedge clk); host_wr = 1'b0;
      dp_rdata = 16'hBEEF; host_rd = 1'b1;
      #1;
      chk("R10 dp_rd_stb", 32'(dp_rd_stb), 32'h1);
      chk("R10 read data", 32'(host_rdata), 32'hBEEF);
      @(negedge clk); host_rd = 1'b0; host_sel = 2'b00;
      chk("R10 feature untouched", 32'(feat_o), 32'h71);

      // R5: command issue
      bus_wr(4'd7, 2'b01, 16'h0030);
      chk("R5 cmd_stb", 32'(cmd_stb), 32'h1);
      chk("R5 cmd_code", 32'(cmd_code), 32'h30);
      @(negedge clk);
      chk("R5 cmd_stb one cycle", 32'(cmd_stb), 32'h0);
      bus_rd(4'd14, 2'b01, rd);
      chk("R5 busy in status", 32'(rd), 32'(exp_status(1'b1)));

      // R6: writes ignored while busy
      bus_wr(4'd3, 2'b01, 16'h00EE);
      bus_rd(4'd3, 2'b01, rd);
      chk("R6 task write ignored", 32'(rd), 32'(m_reg[3]));
      chk("R6 lba unchanged", 32'(lba_o), 32'(exp_lba()));
      bus_wr(4'd0, 2'b10, 16'h0099);
      chk("R6 feature ignored", 32'(feat_o), 32'h71);
      bus_wr(4'd7, 2'b01, 16'h0020);
      chk("R6 cmd ignored strobe", 32'(cmd_stb), 32'h0);
      chk("R6 cmd ignored code", 32'(cmd_code), 32'h30);

      // R7 / R11 / R8
      bus_wr(4'd14, 2'b01, 16'h0002);
      done_pulse();
      chk("R7 masked irq", 32'(irq_o), 32'h0);
      bus_rd(4'd14, 2'b01, rd);
      chk("R11 busy cleared", 32'(rd[7]), 32'h0);
      bus_wr(4'd14, 2'b01, 16'h0000);
      chk("R7 unmasked irq", 32'(irq_o), 32'h1);
      bus_rd(4'd14, 2'b01, rd);
      chk("R8 alt keeps irq", 32'(irq_o), 32'h1);
      bus_rd(4'd7, 2'b01, rd);
      chk("R8 status clears irq", 32'(irq_o), 32'h0);

      for (int k = 0; k < 6; k++) begin
         logic msk;
         msk = 1'($urandom);
         code = 8'($urandom);
         bus_wr(4'd14, 2'b01, {14'h0, msk, 1'b0});
         bus_wr(4'd7, 2'b01, {8'h00, code});
         chk("R5 random cmd", 32'(cmd_code), 32'(code));
         chk("R5 irq cleared by cmd", 32'(irq_o), 32'h0);
         if (k == 2) begin
            bus_wr(4'd14, 2'b01, 16'h0002);
            msk = 1'b1;
         end
         done_pulse();
         chk("R11 irq after done", 32'(irq_o), 32'(!msk));
         bus_rd(4'd7, 2'b01, rd);
         chk("R11 status after done", 32'(rd), 32'(exp_status(1'b0)));
         bus_wr(4'd14, 2'b01, 16'h0000);
         chk("R8 pending cleared", 32'(irq_o), 32'h0);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule